// File: doc/BRIEF.md
# Quad-Output Serial Flash Read Responder

This block is the device-side logic of a serial flash that answers the quad-output fast read command. A host lowers chip select and sends everything one bit at a time on data pin 0, with each bit taken on a rising edge of the serial clock. It sends the command byte 6Bh, then a 24-bit start address with the most significant bit first, then eight dummy clocks. The block then turns all four data pins into outputs. On every falling clock edge it presents one nibble of the memory contents, so one byte takes two clocks.

The read address steps up by one after every complete byte. When it passes the top of the array it returns to zero, so a single command can stream the whole array, and keep going, for as long as chip select stays low. Raising chip select ends the transfer at any point. Any other command byte is dropped without driving a pin. The array holds 2^ADDR_W bytes, and its contents are a fixed pattern that is loaded at reset. The serial pins are sampled on a faster system clock, `clk`, which is assumed to be synchronous to the host that drives them.

Top module: `qrd_responder`

## Requirements
- R1: During reset and while chip select is high, `dq_oe` is 0000 and `prot_bypass` is 0. After reset, the byte at array index i is (29*i + 90) mod 256.
- R2: A command byte of 6Bh, a 24-bit address sent most significant bit first and eight dummy bits, all taken on rising serial clock edges, start a read at that address. The first byte driven is the array byte at that address.
- R3: `dq_oe` stays 0000 through all 40 header bits. It becomes 1111 on the first falling serial clock edge after the 40th rising edge, and at no time is it anything other than 0000 or 1111.
- R4: Each byte leaves as two nibbles, high nibble first, with `dq_out[3]` carrying the most significant bit of each nibble. `dq_out` changes only on a falling serial clock edge.
- R5: The read address increases by one after each complete byte.
- R6: After the byte at the top index 2^ADDR_W-1, the read continues at index 0.
- R7: If the first eight bits are anything other than 6Bh, no pin is driven and `prot_bypass` stays 0 until chip select rises. The next transaction after that behaves normally.
- R8: A rise of chip select in any phase releases all four pins by the next `clk` edge and returns the block to waiting for a command.
- R9: `prot_bypass` is 1 from the recognition of 6Bh until chip select rises. While it is 0, `hold_n` low makes the block ignore rising serial clock edges. While it is 1, `hold_n` has no effect.
- R10: Address bits at position ADDR_W and above are ignored, so the start index is the address modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| dq0_in | input | 1 | Serial input bit for the command, address and dummy phases |
| hold_n | input | 1 | Pause request, active low; it applies only before the command is recognised |
| dq_out | output | 4 | Read data nibble; bit 3 is the most significant bit |
| dq_oe | output | 4 | Output enable, one bit per data pin |
| prot_bypass | output | 1 | High while write-protect and hold are disabled for the current read |

## Verification
The bench builds the block with ADDR_W = 6, which gives a 64-byte array. With that size, start addresses such as 3Ch and 3Fh reach the wrap from the top index to zero within a few bytes. A start address with bits set above bit 5 then shows that the upper address bits are dropped. The default ADDR_W of 8 uses the same logic, and the array just grows with it.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

    localparam logic [7:0] QUAD_READ_CMD = 8'h6B;
    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int DUMMY_BITS = 8;
    localparam int ADDR_END   = CMD_BITS + ADDR_BITS;
    localparam int HDR_BITS   = ADDR_END + DUMMY_BITS;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic active;
        logic rise;
        logic fall;
    } sck_evt_t;

    function automatic logic [7:0] fill_byte(input int unsigned idx);
        int unsigned v;
        v = (idx * 29 + 90) & 255;
        return v[7:0];
    endfunction

    function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic hi);
        return hi ? b[7:4] : b[3:0];
    endfunction

endpackage

// File: rtl/qrd_sck_edges.sv
module qrd_sck_edges
    import qrd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    output sck_evt_t evt
);

    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    assign evt.active = ~cs_n;
    assign evt.rise   = ~cs_n & sck & ~sck_q;
    assign evt.fall   = ~cs_n & ~sck & sck_q;

endmodule

// File: rtl/qrd_header.sv
module qrd_header
    import qrd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sck_evt_t          evt,
    input  logic              dq0_in,
    input  logic              hold_n,
    output phase_e            phase,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_word
);

    localparam int SR_W  = (ADDR_W > CMD_BITS) ? ADDR_W : CMD_BITS;
    localparam int CNT_W = $clog2(HDR_BITS + 1);

    logic [SR_W-2:0]  shreg;
    logic [SR_W-1:0]  word;
    logic [CNT_W-1:0] bit_cnt;
    logic             take;

    assign word = {shreg, dq0_in};
    assign take = evt.rise &&
                  ((phase == PH_ADDR) || (phase == PH_DUMMY) ||
                   ((phase == PH_CMD) && hold_n));

    always_ff @(posedge clk) begin
        if (rst || !evt.active) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            shreg     <= '0;
            addr_load <= 1'b0;
            addr_word <= '0;
        end else begin
            addr_load <= 1'b0;
            if (take) begin
                shreg   <= word[SR_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(CMD_BITS - 1)) begin
                    phase <= (word[7:0] == QUAD_READ_CMD) ? PH_ADDR : PH_IGNORE;
                end else if (bit_cnt == CNT_W'(ADDR_END - 1)) begin
                    phase     <= PH_DUMMY;
                    addr_load <= 1'b1;
                    addr_word <= word[ADDR_W-1:0];
                end else if (bit_cnt == CNT_W'(HDR_BITS - 1)) begin
                    phase <= PH_DATA;
                end
            end
        end
    end

    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (bit_cnt == CNT_W'(HDR_BITS))); // R3

    AST_IGNORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE && evt.active) |=> (phase == PH_IGNORE)); // R7

endmodule

// File: rtl/qrd_array.sv
module qrd_array
    import qrd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [7:0]        rd_byte
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= fill_byte(i);
            end
        end
    end

    assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/qrd_streamer.sv
module qrd_streamer
    import qrd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sck_evt_t          evt,
    input  phase_e            phase,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] rd_idx,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe
);

    logic nib_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0;
            nib_hi <= 1'b1;
            dq_out <= '0;
            dq_oe  <= '0;
        end else if (!evt.active) begin
            dq_oe  <= '0;
            nib_hi <= 1'b1;
        end else if (addr_load) begin
            rd_idx <= addr_word;
            nib_hi <= 1'b1;
        end else if (evt.fall && phase == PH_DATA) begin
            dq_out <= pick_nibble(rd_byte, nib_hi);
            dq_oe  <= '1;
            nib_hi <= ~nib_hi;
            if (!nib_hi) rd_idx <= rd_idx + 1'b1;
        end
    end

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> $stable(dq_out)); // R4

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !evt.active |=> (dq_oe == 4'h0)); // R8

    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (dq_oe == 4'h0) || (dq_oe == 4'hF)); // R3

endmodule

// File: rtl/qrd_responder.sv
module qrd_responder
    import qrd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       dq0_in,
    input  logic       hold_n,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe,
    output logic       prot_bypass
);

    sck_evt_t          evt;
    phase_e            phase;
    logic              addr_load;
    logic [ADDR_W-1:0] addr_word;
    logic [ADDR_W-1:0] rd_idx;
    logic [7:0]        rd_byte;

    qrd_sck_edges u_edges (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .cs_n (cs_n),
        .evt  (evt)
    );

    qrd_header #(.ADDR_W(ADDR_W)) u_header (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .dq0_in    (dq0_in),
        .hold_n    (hold_n),
        .phase     (phase),
        .addr_load (addr_load),
        .addr_word (addr_word)
    );

    qrd_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

    qrd_streamer #(.ADDR_W(ADDR_W)) u_streamer (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .phase     (phase),
        .addr_load (addr_load),
        .addr_word (addr_word),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    assign prot_bypass = (phase == PH_ADDR) || (phase == PH_DUMMY) || (phase == PH_DATA);

    AST_OE_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != 4'h0) |-> prot_bypass); // R9

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE) |-> (dq_oe == 4'h0 && !prot_bypass)); // R7

endmodule

// File: tb/qrd_responder_tb.sv
module qrd_responder_tb_top;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       dq0 = 1'b0;
    logic       hold_n = 1'b1;
    logic [3:0] dq_out;
    logic [3:0] dq_oe;
    logic       prot_bypass;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    qrd_responder #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sck         (sck),
        .dq0_in      (dq0),
        .hold_n      (hold_n),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .prot_bypass (prot_bypass)
    );

    // start address in [31:8], byte count in [7:0]
    localparam logic [31:0] VEC [5] = '{
        32'h000005_03,
        32'h00003C_06,
        32'hABCD12_04,
        32'h00003F_02,
        32'h000020_03
    };

    function automatic logic [7:0] expect_byte(input int unsigned a);
        int unsigned v;
        v = ((a % DEPTH) * 29 + 90) % 256;
        return v[7:0];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        dq0 = b; sck = 1'b0; tick(2);
        sck = 1'b1; tick(2);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
    endtask

    task automatic put_addr(input logic [23:0] a);
        for (int i = 23; i >= 0; i--) put_bit(a[i]);
    endtask

    task automatic begin_txn();
        cs_n = 1'b0; sck = 1'b0; tick(2);
    endtask

    task automatic end_txn();
        cs_n = 1'b1; sck = 1'b0; tick(3);
    endtask

    task automatic grab_nib(output logic [3:0] n);
        sck = 1'b0; tick(2);
        n = dq_out;
        chk("R3", "oe while streaming", 32'(dq_oe), 32'hF);
        sck = 1'b1; tick(2);
        chk("R4", "nibble held over rising edge", 32'(dq_out), 32'(n));
    endtask

    task automatic grab_byte(output logic [7:0] b);
        logic [3:0] hi, lo;
        grab_nib(hi);
        grab_nib(lo);
        b = {hi, lo};
    endtask

    task automatic header(input logic [23:0] a);
        put_byte(8'h6B);
        put_addr(a);
        put_byte(8'hFF);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        tick(4);
        chk("R1", "oe in reset", 32'(dq_oe), 32'h0);
        rst = 1'b0;
        tick(2);
        chk("R1", "oe idle", 32'(dq_oe), 32'h0);
        chk("R1", "bypass idle", 32'(prot_bypass), 32'h0);

        // table walk: R2 R5 R6 R10
        for (int v = 0; v < 5; v++) begin
            logic [23:0] a;
            int cnt;
            a = VEC[v][31:8];
            cnt = int'(VEC[v][7:0]);
            begin_txn();
            header(a);
            chk("R3", "oe after 40 header bits", 32'(dq_oe), 32'h0);
            chk("R9", "bypass after command", 32'(prot_bypass), 32'h1);
            for (int k = 0; k < cnt; k++) begin
                grab_byte(got);
                chk(k == 0 ? "R2" : "R5", "read byte", 32'(got),
                    32'(expect_byte(int'(a % DEPTH) + k)));
            end
            end_txn();
            chk("R8", "oe after cs high", 32'(dq_oe), 32'h0);
            chk("R9", "bypass after cs high", 32'(prot_bypass), 32'h0);
        end

        // R6 explicit: top index then zero
        begin_txn();
        header(24'h00003F);
        grab_byte(got);
        chk("R6", "top byte", 32'(got), 32'(expect_byte(63)));
        grab_byte(got);
        chk("R6", "wrapped byte", 32'(got), 32'(expect_byte(0)));
        end_txn();

        // R10: upper bits ignored
        begin_txn();
        header(24'hFFFFC1);
        grab_byte(got);
        chk("R10", "high address bits dropped", 32'(got), 32'(expect_byte(1)));
        end_txn();

        // R7: wrong command
        begin_txn();
        put_byte(8'h03);
        chk("R7", "bypass after bad cmd", 32'(prot_bypass), 32'h0);
        put_addr(24'h000004);
        put_byte(8'h00);
        for (int k = 0; k < 4; k++) begin
            sck = 1'b0; tick(2);
            chk("R7", "oe with bad cmd", 32'(dq_oe), 32'h0);
            sck = 1'b1; tick(2);
        end
        end_txn();
        begin_txn();
        header(24'h000009);
        grab_byte(got);
        chk("R7", "read after bad cmd", 32'(got), 32'(expect_byte(9)));
        end_txn();

        // R8: aborts in address phase and in data phase
        begin_txn();
        put_byte(8'h6B);
        for (int k = 0; k < 10; k++) put_bit(1'b1);
        cs_n = 1'b1; sck = 1'b0; tick(2);
        chk("R8", "bypass after abort in address", 32'(prot_bypass), 32'h0);
        tick(2);
        begin_txn();
        header(24'h000011);
        grab_nib(got[7:4]);
        cs_n = 1'b1; tick(2);
        chk("R8", "oe after abort in data", 32'(dq_oe), 32'h0);
        sck = 1'b0; tick(2);
        begin_txn();
        header(24'h000012);
        grab_byte(got);
        chk("R8", "read after abort", 32'(got), 32'(expect_byte(18)));
        end_txn();

        // R9: hold during command pauses; hold after recognition ignored
        begin_txn();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        hold_n = 1'b0;
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
        hold_n = 1'b1;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        chk("R9", "bypass after held command", 32'(prot_bypass), 32'h1);
        hold_n = 1'b0;
        put_addr(24'h000007);
        put_byte(8'h00);
        grab_byte(got);
        chk("R9", "read with hold low", 32'(got), 32'(expect_byte(7)));
        grab_byte(got);
        chk("R5", "next byte with hold low", 32'(got), 32'(expect_byte(8)));
        hold_n = 1'b1;
        end_txn();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule